// File: doc/BRIEF.md
# Interrupt Clear-Pending Register Bank

This block holds the per-interrupt state of 64 private peripheral interrupts in the extended range for a single processing element. Each interrupt is in one of four states: inactive, pending, active, or active-and-pending. Software sees the pending half of that state through two 32-bit clear-pending registers. Word index 1 covers interrupts 0 to 31, and word index 2 covers interrupts 32 to 63. The word index counts 32-bit words from the base of the clear-pending window. Writing a 1 to a bit drops the pending state of its interrupt, subject to the interrupt's trigger mode and to the access filter.

Pending state is raised in three ways: a set-pending write on the same bus, a rising edge on an edge-triggered input line, or a level-sensitive line that is held high. An acknowledge strobe moves a pending interrupt to active. A deactivate strobe returns an active interrupt to inactive. Each register bit is filtered per access. Bits of unimplemented interrupts, Secure interrupts seen by a Non-secure access while security is enabled, and interrupts whose security state has affinity routing turned off read as zero and ignore writes.

Top module: `irq_pend_bank`

## Requirements
- R1: After reset every interrupt is inactive and not pending, and every register word reads zero.
- R2: A read of word index 1+k returns, in bit x, 1 when interrupt 32k+x is pending or active-and-pending, and 0 otherwise. The bit is also subject to the filter in R7 to R9.
- R3: A clear write (`bus_set`=0) with bit x at 1 moves a latched pending interrupt to inactive, and an active-and-pending interrupt to active. Bits written 0 change nothing.
- R4: A clear write to an interrupt that is neither pending nor active-and-pending leaves its state unchanged.
- R5: For a level-sensitive interrupt, a clear write does not remove pending while its line is high. A set-pending write keeps it pending after the line falls, until a clear write. With no set-pending and the line low, it is not pending.
- R6: When a set-pending write or an edge-triggered rising edge meets a clear write for the same interrupt in the same cycle, the interrupt ends up pending.
- R7: While `sec_disable`=0, bits of interrupts marked Secure read as zero and ignore writes for Non-secure accesses (`bus_ns`=1). Secure accesses, or `sec_disable`=1, see them normally.
- R8: Bits of interrupts with `cfg_impl`=0 read as zero and ignore writes.
- R9: When affinity routing is off for an interrupt's security state (`route_s_en` for Secure, `route_ns_en` for Non-secure), its bit reads as zero and ignores writes.
- R10: Word indices other than 1 and 2 read as zero, and writes to them have no effect.
- R11: An acknowledge of a pending, non-active interrupt makes it active and drops its latched pending state. An acknowledge of any other interrupt is ignored. A deactivate of an active interrupt makes it inactive.
- R12: For an edge-triggered interrupt, a 0-to-1 transition of its line between successive clock edges makes it pending. A falling line has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | 64 | Interrupt input lines |
| cfg_level | input | 64 | 1 = level-sensitive, 0 = edge-triggered |
| cfg_secure | input | 64 | 1 = interrupt belongs to the Secure state |
| cfg_impl | input | 64 | 1 = interrupt implemented |
| sec_disable | input | 1 | 1 = security filtering off |
| route_s_en | input | 1 | Affinity routing enabled for Secure interrupts |
| route_ns_en | input | 1 | Affinity routing enabled for Non-secure interrupts |
| bus_word | input | 4 | Word index within the clear-pending window |
| bus_wr | input | 1 | Write strobe |
| bus_set | input | 1 | 1 = set-pending write, 0 = clear-pending write |
| bus_ns | input | 1 | 1 = Non-secure access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the bus address |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 6 | Interrupt acknowledged |
| deact_valid | input | 1 | Deactivate strobe |
| deact_id | input | 6 | Interrupt deactivated |
| pending | output | 64 | Effective pending state per interrupt |
| active | output | 64 | Active state per interrupt |

## Verification
The bench attacks a level-sensitive interrupt whose line is still high when it is cleared. A design that cleared it outright would drop pending while the line is asserted, and one that ignored the set-pending history would lose a software-raised pending when the line falls. It also collides a rising edge with a clear write in the same cycle, where the wrong priority loses the interrupt. It sweeps every word index and both access securities over a mix of Secure, unimplemented and unrouted interrupts. A leaky filter there would show a masked bit or let a write reach it.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  // A bit is visible to an access only if its interrupt exists, is routed
  // for its security state, and is not hidden from a Non-secure access.
  function automatic logic bit_open(input logic impl, input logic secure,
                                    input logic route_s, input logic route_ns,
                                    input logic ns_acc, input logic sec_off);
    logic routed;
    routed = secure ? route_s : route_ns;
    return impl & routed & ~(ns_acc & ~sec_off & secure);
  endfunction

  // Register group that holds interrupt idx.
  function automatic int irq_group(input int idx, input int reg_w);
    return idx / reg_w;
  endfunction

endpackage

// File: rtl/irq_access_filter.sv
module irq_access_filter
  import irq_pend_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int REG_W     = 32,
  parameter int FIRST_REG = 1,
  parameter int ADDR_W    = 4
) (
  input  logic [NUM_IRQ-1:0] cfg_secure,
  input  logic [NUM_IRQ-1:0] cfg_impl,
  input  logic               sec_disable,
  input  logic               route_s_en,
  input  logic               route_ns_en,
  input  logic [ADDR_W-1:0]  bus_word,
  input  logic               bus_wr,
  input  logic               bus_set,
  input  logic               bus_ns,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic               word_ok,
  output logic [NUM_IRQ-1:0] allow,
  output logic [NUM_IRQ-1:0] set_req,
  output logic [NUM_IRQ-1:0] clr_req
);
  localparam int NUM_REGS = NUM_IRQ / REG_W;

  int word_idx;
  assign word_idx = int'(bus_word) - FIRST_REG;
  assign word_ok  = (word_idx >= 0) && (word_idx < NUM_REGS);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    localparam int GRP = irq_group(i, REG_W);
    localparam int POS = i % REG_W;
    logic hit;
    assign allow[i]   = bit_open(cfg_impl[i], cfg_secure[i], route_s_en,
                                 route_ns_en, bus_ns, sec_disable);
    assign hit        = bus_wr && word_ok && (word_idx == GRP) && bus_wdata[POS];
    assign set_req[i] = hit && bus_set;
    assign clr_req[i] = hit && !bus_set;
  end

endmodule

// File: rtl/irq_state_cell.sv
module irq_state_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic is_level,
  input  logic allow,
  input  logic set_req,
  input  logic clr_req,
  input  logic ack_req,
  input  logic deact_req,
  output logic pend_eff,
  output logic active_q
);
  logic line_q;
  logic pend_q;
  logic rise, set_ok, clr_ok, ack_ok, deact_ok;

  assign rise     = line && !line_q && !is_level;
  assign set_ok   = set_req && allow;
  assign clr_ok   = clr_req && allow;
  assign pend_eff = pend_q || (is_level && line);
  assign ack_ok   = ack_req && pend_eff && !active_q;
  assign deact_ok = deact_req && active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= 1'b0;
      pend_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      line_q <= line;
      if (set_ok || rise)        pend_q <= 1'b1;
      else if (clr_ok || ack_ok) pend_q <= 1'b0;
      if (ack_ok)                active_q <= 1'b1;
      else if (deact_ok)         active_q <= 1'b0;
    end
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ok || rise) |=> pend_q);

  // R3
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ok && !set_ok && !rise) |=> !pend_q);

  // R7
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !allow && !rise && !ack_ok) |=> (pend_q == $past(pend_q)));

  // R11
  ack_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok && !set_ok && !rise) |=> (active_q && !pend_q));

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_IRQ   = 64,
  parameter int REG_W     = 32,
  parameter int FIRST_REG = 1,
  parameter int ADDR_W    = 4,
  parameter int IDW       = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_line,
  input  logic [NUM_IRQ-1:0] cfg_level,
  input  logic [NUM_IRQ-1:0] cfg_secure,
  input  logic [NUM_IRQ-1:0] cfg_impl,
  input  logic               sec_disable,
  input  logic               route_s_en,
  input  logic               route_ns_en,
  input  logic [ADDR_W-1:0]  bus_word,
  input  logic               bus_wr,
  input  logic               bus_set,
  input  logic               bus_ns,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic               ack_valid,
  input  logic [IDW-1:0]     ack_id,
  input  logic               deact_valid,
  input  logic [IDW-1:0]     deact_id,
  output logic [NUM_IRQ-1:0] pending,
  output logic [NUM_IRQ-1:0] active
);
  localparam int NUM_REGS = NUM_IRQ / REG_W;

  logic               word_ok;
  logic [NUM_IRQ-1:0] allow, set_req, clr_req, ack_req, deact_req, visible;

  irq_access_filter #(
    .NUM_IRQ(NUM_IRQ), .REG_W(REG_W), .FIRST_REG(FIRST_REG), .ADDR_W(ADDR_W)
  ) u_filter (
    .cfg_secure(cfg_secure), .cfg_impl(cfg_impl), .sec_disable(sec_disable),
    .route_s_en(route_s_en), .route_ns_en(route_ns_en),
    .bus_word(bus_word), .bus_wr(bus_wr), .bus_set(bus_set), .bus_ns(bus_ns),
    .bus_wdata(bus_wdata), .word_ok(word_ok), .allow(allow),
    .set_req(set_req), .clr_req(clr_req)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    assign ack_req[i]   = ack_valid   && (ack_id   == IDW'(i));
    assign deact_req[i] = deact_valid && (deact_id == IDW'(i));
    irq_state_cell u_cell (
      .clk(clk), .rst_n(rst_n), .line(irq_line[i]), .is_level(cfg_level[i]),
      .allow(allow[i]), .set_req(set_req[i]), .clr_req(clr_req[i]),
      .ack_req(ack_req[i]), .deact_req(deact_req[i]),
      .pend_eff(pending[i]), .active_q(active[i])
    );
  end

  assign visible = pending & allow;

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (word_ok && (int'(bus_word) == FIRST_REG + k))
        bus_rdata = visible[k*REG_W +: REG_W];
    end
  end

  logic in_window;
  assign in_window = (int'(bus_word) >= FIRST_REG) &&
                     (int'(bus_word) <  FIRST_REG + NUM_REGS);

  // R10
  oob_raz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |-> (bus_rdata == '0));

endmodule

// File: tb/irq_pend_bank_tb.sv
module irq_pend_bank_tb;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_line = '0, cfg_level = '0, cfg_secure = '0, cfg_impl = '1;
  logic        sec_disable = 1'b0, route_s_en = 1'b1, route_ns_en = 1'b1;
  logic [3:0]  bus_word = '0;
  logic        bus_wr = 1'b0, bus_set = 1'b0, bus_ns = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        ack_valid = 1'b0, deact_valid = 1'b0;
  logic [5:0]  ack_id = '0, deact_id = '0;
  logic [N-1:0] pending, active;

  irq_pend_bank u_dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [N-1:0] m_lat = '0, m_act = '0, m_lprev = '0;

  function automatic logic vis(int i, logic ns);
    logic routed;
    routed = cfg_secure[i] ? route_s_en : route_ns_en;
    return cfg_impl[i] && routed && !(ns && !sec_disable && cfg_secure[i]);
  endfunction

  function automatic logic eff(int i);
    return m_lat[i] || (cfg_level[i] && irq_line[i]);
  endfunction

  task automatic step();
    logic [N-1:0] nl, na;
    nl = m_lat; na = m_act;
    for (int i = 0; i < N; i++) begin
      logic wb, rise, ak, dk;
      wb = bus_wr && (bus_word == 4'(1 + i / 32)) && bus_wdata[i % 32] && vis(i, bus_ns);
      rise = irq_line[i] && !m_lprev[i] && !cfg_level[i];
      ak = ack_valid && (ack_id == 6'(i)) && eff(i) && !m_act[i];
      dk = deact_valid && (deact_id == 6'(i)) && m_act[i];
      if ((wb && bus_set) || rise) nl[i] = 1'b1;
      else if ((wb && !bus_set) || ak) nl[i] = 1'b0;
      if (ak) na[i] = 1'b1; else if (dk) na[i] = 1'b0;
    end
    @(posedge clk);
    m_lat = nl; m_act = na; m_lprev = irq_line;
    #1;
    bus_wr = 1'b0; ack_valid = 1'b0; deact_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(int w, logic set, logic ns, logic [31:0] d);
    bus_word = 4'(w); bus_set = set; bus_ns = ns; bus_wdata = d; bus_wr = 1'b1;
    step();
  endtask

  task automatic do_ack(int id);
    ack_id = 6'(id); ack_valid = 1'b1; step();
  endtask

  task automatic do_deact(int id);
    deact_id = 6'(id); deact_valid = 1'b1; step();
  endtask

  task automatic check_all(string tag);
    logic [N-1:0] ep;
    for (int w = 0; w < 4; w++) begin
      for (int ns = 0; ns < 2; ns++) begin
        logic [31:0] exp;
        bus_word = 4'(w); bus_ns = ns[0]; bus_wr = 1'b0;
        #1;
        exp = '0;
        if (w == 1 || w == 2)
          for (int b = 0; b < 32; b++)
            exp[b] = eff((w - 1) * 32 + b) && vis((w - 1) * 32 + b, ns[0]);
        checks++;
        if (bus_rdata !== exp) begin
          errors++;
          $display("FAIL %s word %0d ns %0d: rdata %h expected %h", tag, w, ns, bus_rdata, exp);
        end
      end
    end
    for (int i = 0; i < N; i++) ep[i] = eff(i);
    checks++;
    if (pending !== ep || active !== m_act) begin
      errors++;
      $display("FAIL %s state: pending %h active %h expected %h %h", tag, pending, active, ep, m_act);
    end
  endtask

  task automatic check_bit(string tag, logic actual, logic exp);
    checks++;
    if (actual !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, actual, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    cfg_impl[5] = 1'b0; cfg_impl[40] = 1'b0;
    cfg_secure[10] = 1'b1; cfg_secure[50] = 1'b1;
    cfg_level[20] = 1'b1; cfg_level[33] = 1'b1;

    wr(1, 1, 0, '1); wr(2, 1, 0, '1);
    check_all("R2");

    wr(1, 0, 0, 32'h0000_FFFF); check_all("R3");
    wr(2, 0, 0, 32'h0); check_all("R3");
    wr(1, 0, 0, 32'h0000_FFFF); check_all("R4");

    wr(2, 0, 1, '1); check_all("R7");
    check_bit("R7 secure irq50 kept", pending[50], 1'b1);
    sec_disable = 1'b1;
    wr(2, 0, 1, '1); check_all("R7");
    check_bit("R7 irq50 cleared with security off", pending[50], 1'b0);
    sec_disable = 1'b0;

    wr(2, 1, 0, '1); check_all("R8");
    check_bit("R8 unimplemented irq40", pending[40], 1'b0);

    do_ack(3); check_all("R11");
    check_bit("R11 ack of inactive ignored", active[3], 1'b0);
    wr(1, 1, 0, 32'h8); do_ack(3); check_all("R11");
    check_bit("R11 ack makes active", active[3], 1'b1);
    wr(1, 1, 0, 32'h8); check_all("R3");
    wr(1, 0, 0, 32'h8); check_all("R3");
    check_bit("R3 active-and-pending to active", pending[3], 1'b0);
    do_deact(3); check_all("R11");
    check_bit("R11 deactivate", active[3], 1'b0);

    wr(2, 0, 0, '1);
    irq_line[33] = 1'b1; step(); check_all("R5");
    wr(2, 0, 0, 32'h2); check_all("R5");
    check_bit("R5 level line high keeps pending", pending[33], 1'b1);
    irq_line[33] = 1'b0; step(); check_all("R5");
    check_bit("R5 drops when line low", pending[33], 1'b0);
    wr(2, 1, 0, 32'h2); check_all("R5");
    check_bit("R5 set-pending kept with line low", pending[33], 1'b1);
    wr(2, 0, 0, 32'h2); check_all("R5");

    irq_line[7] = 1'b1;
    wr(1, 0, 0, 32'h80); check_all("R6");
    check_bit("R6 edge beats clear", pending[7], 1'b1);
    wr(1, 0, 0, 32'h80);
    irq_line[7] = 1'b0; step(); check_all("R12");
    check_bit("R12 falling edge ignored", pending[7], 1'b0);
    irq_line[7] = 1'b1; step(); check_all("R12");
    check_bit("R12 rising edge sets", pending[7], 1'b1);
    irq_line[7] = 1'b0;

    wr(1, 1, 0, '1);
    route_ns_en = 1'b0; check_all("R9");
    wr(1, 0, 0, '1); check_all("R9");
    route_ns_en = 1'b1; check_all("R9");
    check_bit("R9 unrouted irq kept", pending[12], 1'b1);

    wr(0, 0, 0, '1); check_all("R10");
    wr(3, 0, 0, '1); check_all("R10");
    wr(3, 1, 0, '1); check_all("R10");
    check_bit("R10 out-of-window set ignored", pending[3], 1'b1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule